// File: doc/BRIEF.md
# Highest Pending Interrupt Readback Unit

This unit sits in the processor-side interface of an interrupt controller. It watches a parameterised set of interrupt sources. Each source has a pending flag, an enable bit, an 8-bit priority and a group bit. The first sixteen sources, which are software-generated, also carry a 3-bit tag naming the CPU interface that raised them. The unit finds the most urgent source that is eligible, holds the result in a register, and offers it as a 32-bit read-only status word on a simple memory-mapped register bus.

Software reads the word to see which interrupt would be delivered next without acknowledging it. The returned value depends on several things: the security state of the access, a global security-disable bit, and the per-group enables at the distributor and at this CPU interface. Depending on these, the word carries either the winning interrupt ID or one of two reserved IDs, 1022 or 1023. Real sources never use those two values, so software can tell a special answer from a real ID.

Top module: `hppi_unit`

## Requirements
- R1: Bits [31:13] of the returned word are always zero. Bits [9:0] carry the interrupt ID, and the ID of source i is i.
- R2: When the reported winner has an ID from 0 to 15, bits [12:10] hold that source's CPU tag, taken from `sgi_cpu_i[3*id +: 3]`. For any higher ID, bits [12:10] are zero.
- R3: Among eligible sources, the lowest numeric priority value wins. When two sources share the lowest priority, the lower ID wins.
- R4: When no source is eligible, a read at the status offset returns 1023.
- R5: A source is eligible only if all three of these hold: it is pending, it is enabled, and its group is enabled at the distributor. Bit g of `dist_grp_en_i` enables group g. A source that is not eligible never takes part in the selection.
- R6: When the winner is in group 0 and the access is non-secure (`secure_i`=0), the read returns 1023.
- R7: When the winner is in group 1, the read returns 1022 in either of two cases: `sec_dis_i`=1, or `secure_i`=1 while `sec_dis_i`=0.
- R8: When the winner's group is disabled at this CPU interface (bit g of `cpu_grp_en_i` is 0), the read returns 1023. This check takes precedence over R6 and R7.
- R9: A request is answered with `ready_o` high in the following cycle. A read at byte offset 0x018 returns the status word. A read at any other offset returns 0. A write returns 0 and changes nothing. With no request, `ready_o`=0 and `rdata_o`=0. After reset, both outputs are 0.
- R10: The winner is captured in a register on every clock. A read sampled on a given edge therefore reflects the source inputs as they stood one edge earlier. The security and enable inputs that choose the special IDs are taken at the read edge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pend_i | input | NUM_SRC | Pending flag, one bit per source |
| en_i | input | NUM_SRC | Enable, one bit per source |
| grp_i | input | NUM_SRC | Group of each source (0 or 1) |
| prio_i | input | 8*NUM_SRC | Priority of source i in bits [8i+7:8i]; lower value is more urgent |
| sgi_cpu_i | input | 48 | CPU tag of software source i (0 to 15) in bits [3i+2:3i] |
| dist_grp_en_i | input | 2 | Distributor group enables |
| cpu_grp_en_i | input | 2 | CPU interface group enables |
| sec_dis_i | input | 1 | Global security-disable |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 12 | Byte offset of the access |
| secure_i | input | 1 | Access is secure |
| rdata_o | output | 32 | Read data |
| ready_o | output | 1 | Response valid |

## Verification
There are two registers on the path, so results arrive at two different times. A change on the source inputs reaches the winner register at the next edge. A read reports that winner one edge later again. The security, enable and group inputs, however, act at the same edge that samples the request.

The bench drives inputs only on falling edges. On each rising edge, its behavioural model first forms the expected response from the winner it computed one edge earlier, and only then recomputes the winner from the current inputs. It compares `ready_o` and `rdata_o` on every falling edge, so each result is checked in exactly the cycle it is due. One directed step changes the sources and issues a read on the same edge, to show that the read returns the older winner.

// File: rtl/hppi_pkg.sv
package hppi_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam int CPU_W  = 3;
  localparam int SGI_N  = 16;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 12;

  localparam logic [ID_W-1:0]   ID_NONE  = 10'd1023;
  localparam logic [ID_W-1:0]   ID_ALT   = 10'd1022;
  localparam logic [ADDR_W-1:0] HPPI_OFF = 12'h018;

  typedef struct packed {
    logic              valid;
    logic [PRIO_W-1:0] prio;
    logic [ID_W-1:0]   id;
    logic              grp;
    logic [CPU_W-1:0]  cpu;
  } cand_t;

  // lo always holds the lower IDs; it keeps ties
  function automatic cand_t pick(cand_t lo, cand_t hi);
    if (lo.valid && (!hi.valid || lo.prio <= hi.prio)) return lo;
    return hi;
  endfunction
endpackage

// File: rtl/hppi_elig.sv
module hppi_elig
  import hppi_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC-1:0]        en_i,
  input  logic [NUM_SRC-1:0]        grp_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [SGI_N*CPU_W-1:0]    sgi_cpu_i,
  input  logic [1:0]                dist_grp_en_i,
  output cand_t                     cand_o [NUM_SRC]
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [CPU_W-1:0] cpu;
    if (i < SGI_N) begin : g_sgi
      assign cpu = sgi_cpu_i[i*CPU_W +: CPU_W];
    end else begin : g_oth
      assign cpu = '0;
    end
    assign cand_o[i].valid = pend_i[i] & en_i[i] & dist_grp_en_i[grp_i[i]];
    assign cand_o[i].prio  = prio_i[i*PRIO_W +: PRIO_W];
    assign cand_o[i].id    = ID_W'(i);
    assign cand_o[i].grp   = grp_i[i];
    assign cand_o[i].cpu   = cpu;
  end
endmodule

// File: rtl/hppi_tree.sv
module hppi_tree
  import hppi_pkg::*;
#(
  parameter int NUM_LEAF = 32
) (
  input  cand_t leaf_i [NUM_LEAF],
  output cand_t win_o
);
  localparam int LVL    = (NUM_LEAF > 1) ? $clog2(NUM_LEAF) : 0;
  localparam int LEAVES = 1 << LVL;
  localparam int NODES  = 2*LEAVES - 1;

  cand_t node [NODES];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < NUM_LEAF) begin : g_real
      assign node[LEAVES-1+i] = leaf_i[i];
    end else begin : g_pad
      assign node[LEAVES-1+i] = '0;
    end
  end

  for (genvar n = 0; n < LEAVES-1; n++) begin : g_node
    assign node[n] = pick(node[2*n+1], node[2*n+2]);
  end

  assign win_o = node[0];
endmodule

// File: rtl/hppi_readback.sv
module hppi_readback
  import hppi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cand_t             win_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              secure_i,
  input  logic              sec_dis_i,
  input  logic [1:0]        cpu_grp_en_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              ready_o
);
  logic              rd_hit;
  logic [ID_W-1:0]   id_sel;
  logic [CPU_W-1:0]  cpu_sel;
  logic [WORD_W-1:0] word;

  assign rd_hit = req_i & ~we_i & (addr_i == HPPI_OFF);

  always_comb begin
    id_sel  = win_i.id;
    cpu_sel = win_i.cpu;
    if (!win_i.valid || !cpu_grp_en_i[win_i.grp]) begin
      id_sel  = ID_NONE;
      cpu_sel = '0;
    end else if (!win_i.grp && !secure_i) begin
      id_sel  = ID_NONE;
      cpu_sel = '0;
    end else if (win_i.grp && (sec_dis_i || secure_i)) begin
      id_sel  = ID_ALT;
      cpu_sel = '0;
    end
    word = {{(WORD_W-ID_W-CPU_W){1'b0}}, cpu_sel, id_sel};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      ready_o <= 1'b0;
    end else begin
      rdata_o <= rd_hit ? word : '0;
      ready_o <= req_i;
    end
  end

  p_hi_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[WORD_W-1:ID_W+CPU_W] == '0);
  p_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ready_o);
  p_wr_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |=> (rdata_o == '0));
  p_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && !win_i.valid) |=> (rdata_o[ID_W-1:0] == ID_NONE));
  p_cpu_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && win_i.valid && !cpu_grp_en_i[win_i.grp]) |=> (rdata_o[ID_W-1:0] == ID_NONE));
  p_ns_grp0_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && win_i.valid && !win_i.grp && cpu_grp_en_i[0] && !secure_i)
    |=> (rdata_o[ID_W-1:0] == ID_NONE));
  p_grp1_alt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && win_i.valid && win_i.grp && cpu_grp_en_i[1] && (sec_dis_i || secure_i))
    |=> (rdata_o[ID_W-1:0] == ID_ALT));
endmodule

// File: rtl/hppi_unit.sv
module hppi_unit
  import hppi_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC-1:0]        en_i,
  input  logic [NUM_SRC-1:0]        grp_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [SGI_N*CPU_W-1:0]    sgi_cpu_i,
  input  logic [1:0]                dist_grp_en_i,
  input  logic [1:0]                cpu_grp_en_i,
  input  logic                      sec_dis_i,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      secure_i,
  output logic [WORD_W-1:0]         rdata_o,
  output logic                      ready_o
);
  cand_t cand [NUM_SRC];
  cand_t win_d, win_q;

  hppi_elig #(.NUM_SRC(NUM_SRC)) u_elig (
    .pend_i       (pend_i),
    .en_i         (en_i),
    .grp_i        (grp_i),
    .prio_i       (prio_i),
    .sgi_cpu_i    (sgi_cpu_i),
    .dist_grp_en_i(dist_grp_en_i),
    .cand_o       (cand)
  );

  hppi_tree #(.NUM_LEAF(NUM_SRC)) u_tree (
    .leaf_i(cand),
    .win_o (win_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_q <= '0;
    else         win_q <= win_d;
  end

  hppi_readback u_rb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .win_i       (win_q),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .secure_i    (secure_i),
    .sec_dis_i   (sec_dis_i),
    .cpu_grp_en_i(cpu_grp_en_i),
    .rdata_o     (rdata_o),
    .ready_o     (ready_o)
  );

  // winner must have been pending and enabled one edge earlier
  logic [NUM_SRC-1:0] pe_q;
  logic               win_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pe_q <= '0;
    else         pe_q <= pend_i & en_i;
  end
  always_comb begin
    win_ok = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (win_q.id == ID_W'(i)) win_ok = pe_q[i];
  end

  p_win_elig_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_q.valid |-> win_ok);
  p_win_id_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_q.valid |-> (32'(win_q.id) < NUM_SRC));
endmodule

// File: tb/hppi_unit_bench.sv
module hppi_unit_bench;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pend = '0, en = '0, grp = '0;
  logic [N*8-1:0] prio = '0;
  logic [47:0]   sgi_cpu = '0;
  logic [1:0]    dist_en = 2'b11, cpu_en = 2'b11;
  logic          sec_dis = 1'b0, req = 1'b0, we = 1'b0, secure = 1'b0;
  logic [11:0]   addr = 12'h018;
  logic [31:0]   rdata;
  logic          ready;

  int tests = 0, fails = 0;
  string cur_req = "R9";
  bit done = 0;

  always #10 clk = ~clk;

  hppi_unit #(.NUM_SRC(N)) u_hppi_unit (
    .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .en_i(en), .grp_i(grp),
    .prio_i(prio), .sgi_cpu_i(sgi_cpu), .dist_grp_en_i(dist_en),
    .cpu_grp_en_i(cpu_en), .sec_dis_i(sec_dis), .req_i(req), .we_i(we),
    .addr_i(addr), .secure_i(secure), .rdata_o(rdata), .ready_o(ready)
  );

  // reference model
  bit m_valid; int m_id, m_prio; bit m_grp;
  logic [31:0] exp_rdata; logic exp_ready;

  function automatic logic [31:0] status_word();
    if (!m_valid || !cpu_en[m_grp]) return 32'd1023;
    if (!m_grp && !secure) return 32'd1023;
    if (m_grp && (sec_dis || secure)) return 32'd1022;
    if (m_id < 16) return (32'(sgi_cpu[m_id*3 +: 3]) << 10) | 32'(m_id);
    return 32'(m_id);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid = 0; m_id = 0; m_prio = 0; m_grp = 0;
      exp_rdata = '0; exp_ready = 1'b0;
    end else begin
      exp_ready = req;
      exp_rdata = (req && !we && addr == 12'h018) ? status_word() : 32'd0;
      m_valid = 0;
      for (int i = 0; i < N; i++) begin
        if (pend[i] && en[i] && dist_en[grp[i]]) begin
          if (!m_valid || int'(prio[i*8 +: 8]) < m_prio) begin
            m_valid = 1; m_id = i; m_prio = int'(prio[i*8 +: 8]); m_grp = grp[i];
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      tests++;
      if (ready !== exp_ready || rdata !== exp_rdata) begin
        fails++;
        $display("FAIL %s: ready=%0b rdata=%0d, expected ready=%0b rdata=%0d",
                 cur_req, ready, rdata, exp_ready, exp_rdata);
      end
      if (rst_n && ready && rdata[31:13] !== '0) begin
        fails++;
        $display("FAIL R1: rdata[31:13]=%0h, expected 0", rdata[31:13]);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_src(int id, bit p, bit e, bit g, int pr);
    pend[id] = p; en[id] = e; grp[id] = g; prio[id*8 +: 8] = 8'(pr);
  endtask

  task automatic rd(bit sec, logic [11:0] a = 12'h018, bit w = 1'b0);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; secure = sec;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    cyc(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) sgi_cpu[i*3 +: 3] = 3'(i % 8);
    cur_req = "R9"; cyc(3); rst_n = 1'b1; cyc(2);

    cur_req = "R4";
    rd(1'b0); rd(1'b1);

    cur_req = "R3";
    set_src(3, 1, 1, 1, 40); set_src(7, 1, 1, 1, 10); set_src(9, 1, 1, 1, 10);
    rd(1'b0);                       // id 7 wins tie, tag bits R2
    set_src(2, 1, 1, 1, 10); rd(1'b0);
    set_src(2, 0, 1, 1, 10);

    cur_req = "R2";
    set_src(20, 1, 1, 1, 0); rd(1'b0);
    set_src(20, 0, 0, 0, 0);

    cur_req = "R5";
    en[7] = 1'b0; rd(1'b0);         // 9 wins
    dist_en = 2'b01; rd(1'b0);      // all group 1 excluded
    dist_en = 2'b11;

    cur_req = "R6";
    set_src(30, 1, 1, 0, 0); rd(1'b0); rd(1'b1);

    cur_req = "R7";
    set_src(30, 0, 0, 0, 0);
    rd(1'b1);
    sec_dis = 1'b1; rd(1'b0); rd(1'b1);
    sec_dis = 1'b0;

    cur_req = "R8";
    cpu_en = 2'b01; rd(1'b0); rd(1'b1);
    cpu_en = 2'b10; set_src(30, 1, 1, 0, 0); rd(1'b1);
    cpu_en = 2'b11;

    cur_req = "R9";
    rd(1'b1, 12'h01C); rd(1'b0, 12'h018, 1'b1); rd(1'b0, 12'h014);

    cur_req = "R10";
    @(negedge clk);
    set_src(30, 0, 0, 0, 0); set_src(5, 1, 1, 1, 1);
    req = 1'b1; we = 1'b0; addr = 12'h018; secure = 1'b0;
    @(negedge clk); @(negedge clk);
    req = 1'b0; cyc(2);

    cur_req = "R3";
    for (int k = 0; k < 800; k++) begin
      @(negedge clk);
      pend = $urandom; en = $urandom | $urandom; grp = $urandom;
      for (int i = 0; i < N; i++) prio[i*8 +: 8] = 8'($urandom_range(0, 3) * 64);
      dist_en = 2'($urandom_range(1, 3)); cpu_en = 2'($urandom_range(0, 3));
      sec_dis = ($urandom_range(0, 3) == 0);
      req = $urandom_range(0, 1); we = ($urandom_range(0, 5) == 0);
      addr = ($urandom_range(0, 7) == 0) ? 12'h020 : 12'h018;
      secure = $urandom_range(0, 1);
    end
    @(negedge clk); req = 1'b0; cyc(3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule